// File: doc/BRIEF.md
# Accumulator Store Rounding and Saturation Unit

This unit turns a 40-bit fixed-point accumulator value into a 16-bit 1.15 fraction for a memory or register store. The 16-bit word is taken from bits 31 to 16. Before it is taken, the unit can round the value in one of two ways: conventional rounding, which is biased slightly toward positive values, or convergent rounding, which removes that bias. After rounding, the word can be clamped to the 1.15 range if store saturation is enabled.

A store is requested by pulsing `store_req` for one cycle while the accumulator and the control inputs are valid. On the next cycle the unit presents the result with a single-cycle write strobe. The destination is either a register, or a memory address held in an internal 16-bit pointer. In the pointer case the store goes to the current pointer value, and the pointer then advances by 2 on the same clock edge. The pointer can be loaded from a port.

Top module: `acc_store_unit`

## Requirements
- R1: With `round_req` = 0 and `sat_en` = 0, `wr_data` equals accumulator bits 31..16, and bits 15..0 have no influence.
- R2: With `round_req` = 1 and `rnd_mode` = 0 (conventional), the result high word is incremented exactly when accumulator bit 15 is 1, i.e. whenever the low word lies in 0x8000..0xFFFF.
- R3: With `round_req` = 1 and `rnd_mode` = 1 (convergent), rounding matches R2 except that when the low word is exactly 0x8000 the high word is incremented only if bit 16 is 1.
- R4: The rounding increment is added to the full 40-bit value, so a carry out of bit 31 reaches bits 39..32 before the saturation test.
- R5: With `sat_en` = 1, if bits 39..31 of the rounded value are not all equal, `wr_data` is 0x7FFF when bit 39 is 0 and 0x8000 when bit 39 is 1; otherwise it is bits 31..16 of the rounded value.
- R6: With `sat_en` = 0, `wr_data` is bits 31..16 of the rounded value, even when the guard bits disagree.
- R7: Every cycle with `store_req` = 1 produces `wr_strobe` = 1 in exactly the following cycle, with `wr_data`, `wr_addr` and `wr_to_reg` valid in that cycle; otherwise `wr_strobe` is 0.
- R8: A store with `dst_indirect` = 1 presents the pointer value held before the store on `wr_addr` with `wr_to_reg` = 0, and the pointer advances by 2 modulo 2^16 at the same edge.
- R9: A store with `dst_indirect` = 0 presents `wr_to_reg` = 1 and `wr_addr` = 0, and leaves the pointer unchanged.
- R10: `ptr_ld` = 1 loads `ptr_ld_val` into the pointer at the next edge. It takes priority over a same-cycle increment, while a coincident indirect store still uses the old pointer value.
- R11: After synchronous reset, `wr_strobe` = 0, `wr_data` = 0, `wr_addr` = 0, `wr_to_reg` = 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| store_req | input | 1 | One-cycle store request |
| acc_in | input | 40 | Accumulator value to store |
| round_req | input | 1 | 1 = round, 0 = truncate |
| rnd_mode | input | 1 | 0 = conventional, 1 = convergent |
| sat_en | input | 1 | Enable clamp to 1.15 range |
| dst_indirect | input | 1 | 1 = store through pointer, 0 = register destination |
| ptr_ld | input | 1 | Load pointer |
| ptr_ld_val | input | 16 | Value for pointer load |
| wr_strobe | output | 1 | One-cycle write strobe |
| wr_data | output | 16 | Stored 1.15 word |
| wr_addr | output | 16 | Store address (pointer value), 0 for register destination |
| wr_to_reg | output | 1 | Destination is a register |

## Verification
The bench targets the exact tie value 0x8000 with both parities of bit 16. A design that rounds ties the conventional way in convergent mode gives a result that is off by one for even high words. A low word of 0x8001 must still round up; a design that tests only bit 15 together with bit 16 would fail to increment there. The carry from 0x7FFF_8000 into the guard bits must trigger saturation. A design that rounds only a 16-bit slice instead wraps to 0x8000 or misses the clamp, and negative values just outside the range must clamp to 0x8000 and not to 0x7FFF. The pointer cases cover wrap from 0xFFFE, register-direct stores that must not move the pointer, and a load that coincides with a store. An off-by-one in the timing of the increment shows up there as a wrong address.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;

    localparam int ACC_W   = 40;
    localparam int WORD_W  = 16;
    localparam int LO_W    = 16;
    localparam int ADDR_W  = 16;
    localparam int ADDR_STEP = 2;

    typedef enum logic {
        RND_CONVENTIONAL = 1'b0,
        RND_CONVERGENT   = 1'b1
    } rnd_mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [ADDR_W-1:0] addr;
        logic              to_reg;
    } store_rec_t;

    // Largest positive and most negative 1.15 words.
    function automatic logic [WORD_W-1:0] word_max();
        return {1'b0, {(WORD_W-1){1'b1}}};
    endfunction

    function automatic logic [WORD_W-1:0] word_min();
        return {1'b1, {(WORD_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/acs_rounder.sv
module acs_rounder
    import acc_store_pkg::*;
#(
    parameter int P_ACC_W = ACC_W,
    parameter int P_LO_W  = LO_W
) (
    input  logic [P_ACC_W-1:0] acc,
    input  logic               round_req,
    input  rnd_mode_e          mode,
    output logic [P_ACC_W-1:0] rounded
);
    localparam int HALF_BIT = P_LO_W - 1;

    logic half_set;
    logic below_half_nz;
    logic keep_lsb;
    logic bump;

    always_comb begin
        half_set      = acc[HALF_BIT];
        below_half_nz = |acc[HALF_BIT-1:0];
        keep_lsb      = acc[P_LO_W];
        bump = 1'b0;
        if (round_req) begin
            if (mode == RND_CONVENTIONAL)
                bump = half_set;
            else
                bump = half_set & (below_half_nz | keep_lsb);
        end
        // Full-width add so the carry reaches the guard bits.
        rounded = acc + (P_ACC_W'(bump) << P_LO_W);
    end

endmodule

// File: rtl/acs_saturator.sv
module acs_saturator
    import acc_store_pkg::*;
#(
    parameter int P_HI_W   = ACC_W - LO_W,
    parameter int P_WORD_W = WORD_W
) (
    input  logic [P_HI_W-1:0]   hi_part,
    input  logic                sat_en,
    output logic [P_WORD_W-1:0] word
);
    localparam int GUARD_N = P_HI_W - P_WORD_W + 1;

    logic [GUARD_N-1:0] guard;
    logic               out_of_range;

    always_comb begin
        guard        = hi_part[P_HI_W-1:P_WORD_W-1];
        out_of_range = !((&guard) || !(|guard));
        if (sat_en && out_of_range)
            word = hi_part[P_HI_W-1] ? word_min() : word_max();
        else
            word = hi_part[P_WORD_W-1:0];
    end

endmodule

// File: rtl/acs_addr_gen.sv
module acs_addr_gen
    import acc_store_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_STEP   = ADDR_STEP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_en,
    input  logic                load_en,
    input  logic [P_ADDR_W-1:0] load_val,
    output logic [P_ADDR_W-1:0] ptr_q
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (load_en)
            ptr_q <= load_val;
        else if (step_en)
            ptr_q <= ptr_q + P_ADDR_W'(P_STEP);
    end

    // R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load_en) |=> (ptr_q == $past(ptr_q) + P_ADDR_W'(P_STEP)));

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !load_en) |=> $stable(ptr_q));

    // R10
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (ptr_q == $past(load_val)));

endmodule

// File: rtl/acc_store_unit.sv
module acc_store_unit
    import acc_store_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              store_req,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic              round_req,
    input  logic              rnd_mode,
    input  logic              sat_en,
    input  logic              dst_indirect,
    input  logic              ptr_ld,
    input  logic [ADDR_W-1:0] ptr_ld_val,
    output logic              wr_strobe,
    output logic [WORD_W-1:0] wr_data,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_to_reg
);
    localparam int HI_W = ACC_W - LO_W;

    logic [ACC_W-1:0]  rounded;
    logic [WORD_W-1:0] sat_word;
    logic [ADDR_W-1:0] ptr_q;
    rnd_mode_e         mode_sel;
    store_rec_t        rec_q;
    logic              strobe_q;

    assign mode_sel = rnd_mode ? RND_CONVERGENT : RND_CONVENTIONAL;

    acs_rounder #(.P_ACC_W(ACC_W), .P_LO_W(LO_W)) u_round (
        .acc       (acc_in),
        .round_req (round_req),
        .mode      (mode_sel),
        .rounded   (rounded)
    );

    acs_saturator #(.P_HI_W(HI_W), .P_WORD_W(WORD_W)) u_sat (
        .hi_part (rounded[ACC_W-1:LO_W]),
        .sat_en  (sat_en),
        .word    (sat_word)
    );

    acs_addr_gen #(.P_ADDR_W(ADDR_W), .P_STEP(ADDR_STEP)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .step_en  (store_req && dst_indirect),
        .load_en  (ptr_ld),
        .load_val (ptr_ld_val),
        .ptr_q    (ptr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            rec_q    <= '0;
        end else begin
            strobe_q <= store_req;
            if (store_req) begin
                rec_q.data   <= sat_word;
                rec_q.addr   <= dst_indirect ? ptr_q : '0;
                rec_q.to_reg <= !dst_indirect;
            end
        end
    end

    assign wr_strobe = strobe_q;
    assign wr_data   = rec_q.data;
    assign wr_addr   = rec_q.addr;
    assign wr_to_reg = rec_q.to_reg;

    // R7
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> $past(store_req));

    // R7
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        store_req |=> wr_strobe);

    // R5
    clamp_value_chk: assert property (@(posedge clk) disable iff (rst)
        (store_req && sat_en && (rounded[ACC_W-1] != rounded[LO_W+WORD_W-1]))
        |=> (wr_data == word_max() || wr_data == word_min()));

    // R1
    trunc_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (store_req && !round_req && !sat_en)
        |=> (wr_data == $past(acc_in[LO_W+WORD_W-1:LO_W])));

    // R8
    addr_src_chk: assert property (@(posedge clk) disable iff (rst)
        (store_req && dst_indirect) |=> (wr_addr == $past(ptr_q) && !wr_to_reg));

endmodule

// File: tb/sim_acc_store_unit.sv
module sim_acc_store_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        store_req;
    logic [39:0] acc_in;
    logic        round_req;
    logic        rnd_mode;
    logic        sat_en;
    logic        dst_indirect;
    logic        ptr_ld;
    logic [15:0] ptr_ld_val;
    logic        wr_strobe;
    logic [15:0] wr_data;
    logic [15:0] wr_addr;
    logic        wr_to_reg;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    acc_store_unit u0 (
        .clk(clk), .rst(rst), .store_req(store_req), .acc_in(acc_in),
        .round_req(round_req), .rnd_mode(rnd_mode), .sat_en(sat_en),
        .dst_indirect(dst_indirect), .ptr_ld(ptr_ld), .ptr_ld_val(ptr_ld_val),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .wr_addr(wr_addr),
        .wr_to_reg(wr_to_reg)
    );

    function automatic logic [15:0] ref_word(logic [39:0] a, bit rr, bit md, bit se);
        logic [40:0] s;
        logic [39:0] r;
        bit up;
        up = 1'b0;
        if (rr) begin
            if (a[15:0] > 16'h8000) up = 1'b1;
            else if (a[15:0] == 16'h8000) up = md ? a[16] : 1'b1;
        end
        s = {1'b0, a} + (up ? 41'h10000 : 41'h0);
        r = s[39:0];
        if (se && !(r[39:31] == 9'h000 || r[39:31] == 9'h1FF))
            return r[39] ? 16'h8000 : 16'h7FFF;
        return r[31:16];
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Issue one store; returns with outputs of that store visible.
    task automatic do_store(logic [39:0] a, bit rr, bit md, bit se, bit ind);
        @(negedge clk);
        acc_in = a; round_req = rr; rnd_mode = md; sat_en = se;
        dst_indirect = ind; store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
    endtask

    task automatic data_case(string tag, logic [39:0] a, bit rr, bit md, bit se,
                             logic [15:0] exp);
        do_store(a, rr, md, se, 1'b0);
        check({tag, " strobe"}, 32'(wr_strobe), 32'd1);
        check({tag, " data"}, 32'(wr_data), 32'(exp));
        check({tag, " model"}, 32'(exp), 32'(ref_word(a, rr, md, se)));
    endtask

    task automatic load_ptr(logic [15:0] v);
        @(negedge clk);
        ptr_ld = 1'b1; ptr_ld_val = v;
        @(negedge clk);
        ptr_ld = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 strobe", 32'(wr_strobe), 0);
        check("R11 data", 32'(wr_data), 0);
        check("R11 addr", 32'(wr_addr), 0);
        check("R11 to_reg", 32'(wr_to_reg), 0);
        do_store(40'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R11 ptr zero", 32'(wr_addr), 0);
    endtask

    task automatic t_truncate();
        data_case("R1 trunc", 40'h00_1234_FFFF, 0, 0, 0, 16'h1234);
        data_case("R1 trunc neg", 40'hFF_ABCD_8000, 0, 1, 0, 16'hABCD);
    endtask

    task automatic t_conventional();
        data_case("R2 tie", 40'h00_1234_8000, 1, 0, 0, 16'h1235);
        data_case("R2 below", 40'h00_1234_7FFF, 1, 0, 0, 16'h1234);
        data_case("R2 top", 40'h00_1234_FFFF, 1, 0, 0, 16'h1235);
    endtask

    task automatic t_convergent();
        data_case("R3 tie even", 40'h00_1234_8000, 1, 1, 0, 16'h1234);
        data_case("R3 tie odd", 40'h00_1235_8000, 1, 1, 0, 16'h1236);
        data_case("R3 above", 40'h00_1234_8001, 1, 1, 0, 16'h1235);
        data_case("R3 below", 40'h00_1235_7FFF, 1, 1, 1, 16'h1235);
    endtask

    task automatic t_carry_sat();
        data_case("R4 carry sat", 40'h00_7FFF_8000, 1, 0, 1, 16'h7FFF);
        data_case("R4 neg carry", 40'hFF_FFFF_8000, 1, 0, 1, 16'h0000);
        data_case("R5 pos big", 40'h01_0000_0000, 0, 0, 1, 16'h7FFF);
        data_case("R5 neg big", 40'hFF_7FFF_0000, 0, 0, 1, 16'h8000);
        data_case("R5 in range", 40'hFF_8000_0000, 0, 0, 1, 16'h8000);
    endtask

    task automatic t_no_sat();
        data_case("R6 carry wrap", 40'h00_7FFF_8000, 1, 0, 0, 16'h8000);
        data_case("R6 neg wrap", 40'hFF_7FFF_0000, 0, 0, 0, 16'h7FFF);
    endtask

    task automatic t_strobe();
        @(negedge clk);
        check("R7 idle", 32'(wr_strobe), 0);
        do_store(40'h00_0001_0000, 0, 0, 0, 0);
        do_store(40'h00_0002_0000, 0, 0, 0, 0);
        check("R7 back2back", 32'(wr_strobe), 1);
        check("R7 back2back data", 32'(wr_data), 32'h2);
        @(negedge clk);
        check("R7 single pulse", 32'(wr_strobe), 0);
    endtask

    task automatic t_pointer();
        load_ptr(16'h1000);
        do_store(40'h0, 0, 0, 0, 1);
        check("R8 addr0", 32'(wr_addr), 32'h1000);
        check("R8 to_reg", 32'(wr_to_reg), 0);
        do_store(40'h0, 0, 0, 0, 1);
        check("R8 addr1", 32'(wr_addr), 32'h1002);
        do_store(40'h0, 0, 0, 0, 0);
        check("R9 to_reg", 32'(wr_to_reg), 1);
        check("R9 addr", 32'(wr_addr), 0);
        do_store(40'h0, 0, 0, 0, 1);
        check("R9 ptr kept", 32'(wr_addr), 32'h1004);
        load_ptr(16'hFFFE);
        do_store(40'h0, 0, 0, 0, 1);
        check("R8 wrap a", 32'(wr_addr), 32'hFFFE);
        do_store(40'h0, 0, 0, 0, 1);
        check("R8 wrap b", 32'(wr_addr), 32'h0000);
    endtask

    task automatic t_load_priority();
        load_ptr(16'h0100);
        @(negedge clk);
        acc_in = 40'h0; round_req = 0; rnd_mode = 0; sat_en = 0;
        dst_indirect = 1; store_req = 1; ptr_ld = 1; ptr_ld_val = 16'h2000;
        @(negedge clk);
        store_req = 0; ptr_ld = 0;
        check("R10 old ptr used", 32'(wr_addr), 32'h0100);
        do_store(40'h0, 0, 0, 0, 1);
        check("R10 load wins", 32'(wr_addr), 32'h2000);
    endtask

    initial begin
        rst = 1'b1; store_req = 0; acc_in = '0; round_req = 0; rnd_mode = 0;
        sat_en = 0; dst_indirect = 0; ptr_ld = 0; ptr_ld_val = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_truncate();
        t_conventional();
        t_convergent();
        t_carry_sat();
        t_no_sat();
        t_strobe();
        t_pointer();
        t_load_priority();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule